// File: doc/BRIEF.md
# Locked Configuration Index Port

This block is a host-side configuration space for a multifunction legacy I/O controller. The host reaches it through two byte-wide I/O ports, an index port and a data port. The space is normally sealed. A fixed one-byte key written to the index port opens it, and a second key seals it again. While the space is open, the host writes a register number to the index port and then reads or writes that register through the data port.

The register file has two parts. The global part, below index 0x30, holds a constant device identifier, the logical-device selector and a read-only copy of the configuration port's own base address. The banked part, from index 0x30 up, is a per-device window: an enable bit, a 16-bit I/O base given as two bytes, and an interrupt line number. The selector decides which device's bank the window reaches. Only the devices named in a parameter mask have a bank. The stored enable, base and interrupt values of every device leave the block as flat vectors for the logic that decodes each device.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the space is sealed, the index and the selector are 0x00, and every dev_en, dev_base and dev_irq bit is 0.
- R2: An index-port write (io_addr=0) of 0x5A opens the space. An index-port write of 0xA5 while open seals it. While sealed, any other index-port write has no effect.
- R3: While sealed, data-port writes (io_addr=1) change nothing, and a read of either port returns 0xFF.
- R4: While open, an index-port write of any value other than 0x5A or 0xA5 becomes the current index, and a read of the index port returns that index.
- R5: Register 0x00 always reads 0xB7 (the DEV_ID parameter), and writes to it have no effect.
- R6: Register 0x07 is a read/write 8-bit selector. Accesses to registers 0x30 and above go to the bank of the device whose number equals the selector.
- R7: In a bank, bit 0 of register 0x30 is the device enable and drives dev_en[n]. The register reads back with bits 7:1 as zero.
- R8: In a bank, register 0x60 is bits 15:8 of the device base and register 0x61 is bits 7:0. Together they drive dev_base[16n+15:16n]. Register 0x70 holds the interrupt number and drives dev_irq[8n+7:8n]. All three read back as written.
- R9: Register 0x26 reads the low byte and register 0x27 reads the high byte of the CFG_PORT_BASE parameter (default 0x0A2E). Both are read-only.
- R10: Only devices whose bit is set in IMPL_MASK have a bank (by default devices 5 and 9). With any other selector value, including values of 16 or more, banked registers read 0x00 and writes to them have no effect.
- R11: Every register index not named above reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Port write strobe, one cycle per write |
| io_rd | input | 1 | Port read strobe; io_rdata is valid in the same cycle |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 0x00 when io_rd is low |
| dev_en | output | NUM_LDN | Enable of each device |
| dev_base | output | 16*NUM_LDN | I/O base of each device, device n at bits 16n+15:16n |
| dev_irq | output | 8*NUM_LDN | Interrupt number of each device, device n at bits 8n+7:8n |

## Verification
Corruption in the key logic shows up on the very next read of either port, which returns 0xFF when it should not, or does not return 0xFF when it should. A wrong selector or a wrong bank write enable shows up one cycle after the data-port write, when a value reaches the wrong device's slice of dev_base, dev_irq or dev_en. An error in the read decode is visible in the same cycle as the read strobe. The bench walks every index under several selector values, sealed and open. That sweep exposes a stray decode within one pass.

// File: rtl/cfgp_pkg.sv
// Package: shared key values, register indices and the per-device record
// of the configuration index port.
package cfgp_pkg;
    localparam logic [7:0] KEY_OPEN  = 8'h5A;
    localparam logic [7:0] KEY_CLOSE = 8'hA5;

    localparam logic [7:0] RX_ID     = 8'h00;
    localparam logic [7:0] RX_LDN    = 8'h07;
    localparam logic [7:0] RX_PB_LO  = 8'h26;
    localparam logic [7:0] RX_PB_HI  = 8'h27;
    localparam logic [7:0] RX_BANK0  = 8'h30;
    localparam logic [7:0] RX_EN     = 8'h30;
    localparam logic [7:0] RX_BHI    = 8'h60;
    localparam logic [7:0] RX_BLO    = 8'h61;
    localparam logic [7:0] RX_IRQ    = 8'h70;

    typedef struct packed {
        logic        en;
        logic [15:0] base;
        logic [7:0]  irq;
    } ldev_cfg_t;
endpackage

// File: rtl/cfgp_gate.sv
// Module: cfgp_gate
// Does: holds the open/sealed state and the current register index, both
//       driven by index-port writes.
// Assumes: idx_wr is a one-cycle strobe. Key values are never stored as an
//          index.
module cfgp_gate
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open,
    output logic [7:0] index
);
    // Key detection and index capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open  <= 1'b0;
            index <= 8'h00;
        end else if (idx_wr) begin
            if (!open) begin
                if (wdata == KEY_OPEN) open <= 1'b1;
            end else if (wdata == KEY_CLOSE) begin
                open <= 1'b0;
            end else if (wdata != KEY_OPEN) begin
                index <= wdata;
            end
        end
    end
endmodule

// File: rtl/cfgp_bank.sv
// Module: cfgp_bank
// Does: the register bank of one logical device (enable, base, interrupt),
//       with its read-back multiplexer.
// Assumes: wr_en already qualifies the open state, the data port and the
//          device selection.
module cfgp_bank
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output ldev_cfg_t  cfg,
    output logic [7:0] rdata
);
    // Register updates on a qualified data-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (index)
                RX_EN:   cfg.en         <= wdata[0];
                RX_BHI:  cfg.base[15:8] <= wdata;
                RX_BLO:  cfg.base[7:0]  <= wdata;
                RX_IRQ:  cfg.irq        <= wdata;
                default: ;
            endcase
        end
    end

    // Read-back of the addressed bank register.
    always_comb begin
        case (index)
            RX_EN:   rdata = {7'b0, cfg.en};
            RX_BHI:  rdata = cfg.base[15:8];
            RX_BLO:  rdata = cfg.base[7:0];
            RX_IRQ:  rdata = cfg.irq;
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfg_index_port.sv
// Module: cfg_index_port
// Does: keyed index/data configuration space with global registers and
//       per-device banks selected by a logical-device selector.
// Assumes: io_wr and io_rd are never high together. io_rdata is a
//          combinational result valid during io_rd.
module cfg_index_port
    import cfgp_pkg::*;
#(
    parameter int          NUM_LDN       = 16,
    parameter logic [15:0] IMPL_MASK     = 16'h0220,
    parameter logic [7:0]  DEV_ID        = 8'hB7,
    parameter logic [15:0] CFG_PORT_BASE = 16'h0A2E
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic                   io_addr,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic [NUM_LDN-1:0]     dev_en,
    output logic [16*NUM_LDN-1:0]  dev_base,
    output logic [8*NUM_LDN-1:0]   dev_irq
);
    localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    logic             cfg_open;
    logic [7:0]       cfg_index;
    logic [7:0]       cfg_ldn;
    logic             data_wr;
    logic             sel_ok;
    logic [LDN_W-1:0] sel_idx;
    logic [7:0]       bank_rd [NUM_LDN];

    // Index-port state: open/sealed flag and current index.
    cfgp_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (io_wr && !io_addr),
        .wdata  (io_wdata),
        .open   (cfg_open),
        .index  (cfg_index)
    );

    assign data_wr = io_wr && io_addr && cfg_open;
    assign sel_idx = cfg_ldn[LDN_W-1:0];
    assign sel_ok  = ({24'b0, cfg_ldn} < NUM_LDN) && IMPL_MASK[sel_idx];

    // Logical-device selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_ldn <= 8'h00;
        else if (data_wr && cfg_index == RX_LDN)
            cfg_ldn <= io_wdata;
    end

    // One bank per implemented device. Absent devices read and drive zero.
    for (genvar n = 0; n < NUM_LDN; n++) begin : g_ldev
        if (IMPL_MASK[n]) begin : g_impl
            ldev_cfg_t cfg;
            cfgp_bank u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (data_wr && cfg_index >= RX_BANK0 &&
                        {24'b0, cfg_ldn} == n),
                .index (cfg_index),
                .wdata (io_wdata),
                .cfg   (cfg),
                .rdata (bank_rd[n])
            );
            assign dev_en[n]            = cfg.en;
            assign dev_base[16*n +: 16] = cfg.base;
            assign dev_irq[8*n +: 8]    = cfg.irq;
        end else begin : g_absent
            assign bank_rd[n]           = 8'h00;
            assign dev_en[n]            = 1'b0;
            assign dev_base[16*n +: 16] = 16'h0000;
            assign dev_irq[8*n +: 8]    = 8'h00;
        end
    end

    // Read multiplexer across the lock state, the ports and the two ranges.
    always_comb begin
        if (!io_rd)
            io_rdata = 8'h00;
        else if (!cfg_open)
            io_rdata = 8'hFF;
        else if (!io_addr)
            io_rdata = cfg_index;
        else if (cfg_index >= RX_BANK0)
            io_rdata = sel_ok ? bank_rd[sel_idx] : 8'h00;
        else begin
            case (cfg_index)
                RX_ID:    io_rdata = DEV_ID;
                RX_LDN:   io_rdata = cfg_ldn;
                RX_PB_LO: io_rdata = CFG_PORT_BASE[7:0];
                RX_PB_HI: io_rdata = CFG_PORT_BASE[15:8];
                default:  io_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/cfgp_checker.sv
// Module: cfgp_checker
// Does: checks the timing properties of the configuration index port. It is
//       bound to every instance of the top module.
// Assumes: sees the top's open flag, index and selector through the bind.
module cfgp_checker #(
    parameter int          NUM_LDN   = 16,
    parameter logic [15:0] IMPL_MASK = 16'h0220,
    parameter logic [7:0]  DEV_ID    = 8'hB7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic                  io_addr,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic                  cfg_open,
    input logic [7:0]            cfg_index,
    input logic [7:0]            cfg_ldn,
    input logic [NUM_LDN-1:0]    dev_en,
    input logic [16*NUM_LDN-1:0] dev_base,
    input logic [8*NUM_LDN-1:0]  dev_irq
);
    localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    logic foreign;
    assign foreign = ({24'b0, cfg_ldn} >= NUM_LDN) ||
                     !IMPL_MASK[cfg_ldn[LDN_W-1:0]];

    p_sealed_reads_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open && io_rd |-> io_rdata == 8'hFF);

    p_sealed_writes_inert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open && io_wr && io_addr |=>
            $stable(dev_en) && $stable(dev_base) && $stable(dev_irq));

    p_open_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && !io_addr && io_wdata == 8'h5A |=> cfg_open);

    p_close_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open && io_wr && !io_addr && io_wdata == 8'hA5 |=> !cfg_open);

    p_id_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open && io_rd && io_addr && cfg_index == 8'h00 |-> io_rdata == DEV_ID);

    p_ldn_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open && io_wr && io_addr && cfg_index == 8'h07 |=>
            cfg_ldn == $past(io_wdata));

    p_foreign_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open && io_wr && io_addr && foreign && cfg_index != 8'h07 |=>
            $stable(dev_en) && $stable(dev_base) && $stable(dev_irq));
endmodule

bind cfg_index_port cfgp_checker #(
    .NUM_LDN   (NUM_LDN),
    .IMPL_MASK (IMPL_MASK),
    .DEV_ID    (DEV_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .cfg_open  (cfg_open),
    .cfg_index (cfg_index),
    .cfg_ldn   (cfg_ldn),
    .dev_en    (dev_en),
    .dev_base  (dev_base),
    .dev_irq   (dev_irq)
);

// File: tb/cfg_index_port_tb.sv
// Bench: sweeps every index, sealed and open, under several selector values,
// and checks each result against an arithmetic model of the requirements.
module cfg_index_port_tb;
    localparam int NL = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            io_wr = 1'b0;
    logic            io_rd = 1'b0;
    logic            io_addr = 1'b0;
    logic [7:0]      io_wdata = 8'h00;
    logic [7:0]      io_rdata;
    logic [NL-1:0]   dev_en;
    logic [16*NL-1:0] dev_base;
    logic [8*NL-1:0] dev_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state.
    bit       m_en  [NL];
    logic [7:0] m_hi [NL];
    logic [7:0] m_lo [NL];
    logic [7:0] m_irq [NL];
    logic [7:0] m_ldn;

    always #5 clk = ~clk;

    cfg_index_port u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_en(dev_en), .dev_base(dev_base), .dev_irq(dev_irq)
    );

    function automatic bit impl(input logic [7:0] l);
        return (l == 8'd5) || (l == 8'd9);
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] idx);
        logic [3:0] s;
        s = m_ldn[3:0];
        case (idx)
            8'h00: return 8'hB7;
            8'h07: return m_ldn;
            8'h26: return 8'h2E;
            8'h27: return 8'h0A;
            8'h30: return impl(m_ldn) ? {7'b0, m_en[s]} : 8'h00;
            8'h60: return impl(m_ldn) ? m_hi[s] : 8'h00;
            8'h61: return impl(m_ldn) ? m_lo[s] : 8'h00;
            8'h70: return impl(m_ldn) ? m_irq[s] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        @(posedge clk);
        #1 io_rd = 1'b0;
    endtask

    task automatic check_outputs(input string req);
        for (int n = 0; n < NL; n++) begin
            check(req, {31'b0, dev_en[n]}, {31'b0, m_en[n]});
            check(req, {16'b0, dev_base[16*n +: 16]}, {16'b0, m_hi[n], m_lo[n]});
            check(req, {24'b0, dev_irq[8*n +: 8]}, {24'b0, m_irq[n]});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] v;
        logic [7:0] ldn_list [6];
        ldn_list = '{8'd5, 8'd9, 8'd0, 8'd3, 8'd15, 8'd200};
        for (int n = 0; n < NL; n++) begin
            m_en[n] = 1'b0; m_hi[n] = 8'h00; m_lo[n] = 8'h00; m_irq[n] = 8'h00;
        end
        m_ldn = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, with outputs cleared and the space sealed.
        check_outputs("R1");
        bus_rd(1'b1, r); check("R1 sealed after reset", {24'b0, r}, 32'hFF);

        // R2/R3: sealed sweep. Every non-key index and data write is ignored.
        for (int i = 0; i < 256; i++) begin
            if (i == 8'h5A) continue;
            bus_wr(1'b0, i[7:0]);
            bus_wr(1'b1, i[7:0]);
            bus_rd(1'b1, r); check("R3 sealed data read", {24'b0, r}, 32'hFF);
            bus_rd(1'b0, r); check("R2 sealed index read", {24'b0, r}, 32'hFF);
        end
        check_outputs("R3");

        // R2: open, then the index reads back 0x00 (R1: index reset).
        bus_wr(1'b0, 8'h5A);
        bus_rd(1'b0, r); check("R2 open, R1 index zero", {24'b0, r}, 32'h00);

        foreach (ldn_list[k]) begin
            bus_wr(1'b0, 8'h07);
            bus_wr(1'b1, ldn_list[k]);
            m_ldn = ldn_list[k];
            // Write sweep of R5-R11 over every non-key index except the selector.
            for (int i = 0; i < 256; i++) begin
                if (i == 8'h5A || i == 8'hA5 || i == 8'h07) continue;
                v = 8'((i * 7) + ldn_list[k] + 1);
                bus_wr(1'b0, i[7:0]);
                bus_wr(1'b1, v);
                if (impl(m_ldn)) begin
                    case (i[7:0])
                        8'h30: m_en[m_ldn[3:0]]  = v[0];
                        8'h60: m_hi[m_ldn[3:0]]  = v;
                        8'h61: m_lo[m_ldn[3:0]]  = v;
                        8'h70: m_irq[m_ldn[3:0]] = v;
                        default: ;
                    endcase
                end
            end
            // Read sweep. Covers R4 index read-back and the R5-R11 register values.
            for (int i = 0; i < 256; i++) begin
                if (i == 8'h5A || i == 8'hA5) continue;
                bus_wr(1'b0, i[7:0]);
                bus_rd(1'b0, r); check("R4 index readback", {24'b0, r}, i);
                bus_rd(1'b1, r);
                check("R5 R6 R7 R8 R9 R10 R11 data read", {24'b0, r}, {24'b0, exp_data(i[7:0])});
            end
            check_outputs("R7 R8 R10 outputs");
        end

        // R2: seal with 0xA5. Reads return 0xFF and data writes stay inert.
        bus_wr(1'b0, 8'h05); // R6: index 0x05 before sealing
        bus_wr(1'b0, 8'h07);
        bus_wr(1'b1, 8'h09);
        m_ldn = 8'h09;
        bus_wr(1'b0, 8'h60);
        bus_wr(1'b0, 8'hA5);
        bus_rd(1'b1, r); check("R2 sealed by key", {24'b0, r}, 32'hFF);
        bus_wr(1'b1, 8'h77);
        check_outputs("R3 write while sealed");
        // Reopen. The index (0x60) and the selector (9) are kept.
        bus_wr(1'b0, 8'h5A);
        bus_rd(1'b0, r); check("R2 index kept across seal", {24'b0, r}, 32'h60);
        bus_rd(1'b1, r); check("R8 base high after reopen", {24'b0, r}, {24'b0, m_hi[9]});
        // R2: 0x5A while open is not stored as an index.
        bus_wr(1'b0, 8'h5A);
        bus_rd(1'b0, r); check("R2 key not stored", {24'b0, r}, 32'h60);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule